// File: doc/BRIEF.md
# Flag-Polled Interrupt Controller

This block gathers single-cycle event pulses from fourteen sources into sticky flag bits, one per source. Each flag is paired with its own enable bit, and one global enable sits above all of them. The flags are split into three groups: the core group (pin edge, port change, timer-0 overflow), a first peripheral group (seven sources) and a second peripheral group (four sources). When any enabled flag is set and the global enable is on, the block raises a single request toward the processor core. There is no priority and no per-source vector. Software finds the cause by reading the flags.

The core marks the end of each instruction cycle with `cycleEnd`. If the request is present on such a boundary, the block takes the interrupt. In that cycle it pulses a push-return-address strobe and a load-vector strobe, and it presents the fixed vector 0x0004. It also clears the global enable on the same clock edge. A return-from-interrupt pulse sets the global enable again. Software reads and writes all flags and enables over a simple register bus. A flag is cleared only when software writes it.

Top module: `irqctl`

## Requirements
- R1: A source pulse sampled on a clock edge sets that source's flag. This happens whatever the state of its enable bit or the global enable. The flag can be read on the next cycle.
- R2: `irqReq` is high exactly when the global enable is set and at least one source has both its flag and its enable bit set.
- R3: After reset, all flags, enables and the global enable are 0, and `irqReq` and `pushRet` are low.
- R4: An interrupt is taken in a cycle where `cycleEnd` is high and `irqReq` is high. In that cycle `pushRet` and `loadVector` are high and `pcVector` equals 0x0004. From the next cycle on, the global enable is 0.
- R5: A `retIrq` pulse sets the global enable, unless an interrupt is taken in the same cycle.
- R6: Taking an interrupt leaves the flags unchanged. A flag that is still set raises `irqReq` again as soon as the global enable returns. Writing 0 to the flag clears it.
- R7: A register write that clears the global enable drops an interrupt on the same `cycleEnd`. The flag stays set, and the interrupt is taken on a later boundary once the global enable is set again.
- R8: No interrupt is taken while `cycleEnd` is low, even with `irqReq` high.
- R9: A source pulse in the same cycle as a software write of 0 to that flag leaves the flag set.
- R10: Register map, 8-bit data, registers reset to 0:
  - Address 0 holds the core flags in bits 2:0 (bit 0 pin edge, bit 1 port change, bit 2 timer-0), the core enables in bits 5:3 in the same order, and the global enable in bit 7.
  - Address 1 holds the first group's flags in bits 6:0, and address 2 holds its enables.
  - Address 3 holds the second group's flags in bits 3:0, and address 4 holds its enables.
  - Unused bits read 0. Addresses 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| coreSrc | input | 3 | Core-group event pulses |
| periphASrc | input | 7 | First peripheral group event pulses |
| periphBSrc | input | 4 | Second peripheral group event pulses |
| cycleEnd | input | 1 | Instruction-cycle boundary strobe from the core |
| retIrq | input | 1 | Return-from-interrupt pulse |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irqReq | output | 1 | Interrupt request to the core |
| pushRet | output | 1 | Push return address strobe |
| loadVector | output | 1 | Load program counter strobe |
| pcVector | output | 13 | Interrupt vector address |

## Verification
A global enable that is stuck or set wrongly shows up at once on `irqReq`. It is also visible on the next boundary, through an entry that is missing or one that should not happen. A flag that is lost or cleared early shows up on the next read of its register, and also as a request that fails to return after `retIrq`. The checks therefore compare `irqReq`, `pushRet` and read data in the same cycle as the stimulus or in the cycle right after it.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;
  localparam int CORE_N = 3;
  localparam int PA_N   = 7;
  localparam int PB_N   = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int PC_W   = 13;
  localparam int NREG   = 5;
  localparam int GLB_BIT = 7;
  localparam logic [PC_W-1:0] VEC_ADDR = 13'h0004;

  localparam logic [ADDR_W-1:0] A_CORE = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLGA = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLGB = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENB  = 3'd4;

  typedef struct packed {
    logic            take;
    logic            retSet;
    logic [NREG-1:0] wrSel;
  } ctrlStrobeT;
endpackage

// File: rtl/irqctl_bank.sv
module irqctl_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] srcPulse,
  input  logic         wrFlag,
  input  logic [W-1:0] wdFlag,
  input  logic         wrEnable,
  input  logic [W-1:0] wdEnable,
  output logic [W-1:0] flags,
  output logic [W-1:0] enables,
  output logic         pend
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      // a hardware event wins over a software clear
      flags <= (wrFlag ? wdFlag : flags) | srcPulse;
      if (wrEnable) enables <= wdEnable;
    end
  end

  assign pend = |(flags & enables);
endmodule

// File: rtl/irqctl_ctrl.sv
module irqctl_ctrl
  import irqctl_pkg::*;
(
  input  logic              cycleEnd,
  input  logic              retIrq,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wdGlobal,
  input  logic              anyPend,
  input  logic              globalEn,
  output ctrlStrobeT        strb
);
  logic [NREG-1:0] sel;
  logic clearGlb;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign sel[i] = regWrEn && (regAddr == ADDR_W'(i));
  end

  assign clearGlb    = sel[0] && !wdGlobal;
  assign strb.wrSel  = sel;
  assign strb.retSet = retIrq;
  assign strb.take   = cycleEnd && anyPend && globalEn && !clearGlb;
endmodule

// File: rtl/irqctl_dp.sv
module irqctl_dp
  import irqctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CORE_N-1:0] coreSrc,
  input  logic [PA_N-1:0]   periphASrc,
  input  logic [PB_N-1:0]   periphBSrc,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  ctrlStrobeT        strb,
  output logic [DATA_W-1:0] regRdata,
  output logic [CORE_N-1:0] coreFlags,
  output logic              globalEn,
  output logic              anyPend
);
  logic [CORE_N-1:0] coreEn;
  logic [PA_N-1:0] flagA, enA;
  logic [PB_N-1:0] flagB, enB;
  logic pendCore, pendA, pendB;

  irqctl_bank #(.W(CORE_N)) u_core (
    .clk(clk), .rstN(rstN), .srcPulse(coreSrc),
    .wrFlag(strb.wrSel[A_CORE]), .wdFlag(regWdata[CORE_N-1:0]),
    .wrEnable(strb.wrSel[A_CORE]), .wdEnable(regWdata[2*CORE_N-1:CORE_N]),
    .flags(coreFlags), .enables(coreEn), .pend(pendCore));

  irqctl_bank #(.W(PA_N)) u_grpA (
    .clk(clk), .rstN(rstN), .srcPulse(periphASrc),
    .wrFlag(strb.wrSel[A_FLGA]), .wdFlag(regWdata[PA_N-1:0]),
    .wrEnable(strb.wrSel[A_ENA]), .wdEnable(regWdata[PA_N-1:0]),
    .flags(flagA), .enables(enA), .pend(pendA));

  irqctl_bank #(.W(PB_N)) u_grpB (
    .clk(clk), .rstN(rstN), .srcPulse(periphBSrc),
    .wrFlag(strb.wrSel[A_FLGB]), .wdFlag(regWdata[PB_N-1:0]),
    .wrEnable(strb.wrSel[A_ENB]), .wdEnable(regWdata[PB_N-1:0]),
    .flags(flagB), .enables(enB), .pend(pendB));

  assign anyPend = pendCore | pendA | pendB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   globalEn <= 1'b0;
    else if (strb.take)          globalEn <= 1'b0;
    else if (strb.retSet)        globalEn <= 1'b1;
    else if (strb.wrSel[A_CORE]) globalEn <= regWdata[GLB_BIT];
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CORE: begin
        regRdata[CORE_N-1:0]        = coreFlags;
        regRdata[2*CORE_N-1:CORE_N] = coreEn;
        regRdata[GLB_BIT]           = globalEn;
      end
      A_FLGA:  regRdata[PA_N-1:0] = flagA;
      A_ENA:   regRdata[PA_N-1:0] = enA;
      A_FLGB:  regRdata[PB_N-1:0] = flagB;
      A_ENB:   regRdata[PB_N-1:0] = enB;
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/irqctl.sv
module irqctl
  import irqctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CORE_N-1:0]    coreSrc,
  input  logic [PA_N-1:0]      periphASrc,
  input  logic [PB_N-1:0]      periphBSrc,
  input  logic                 cycleEnd,
  input  logic                 retIrq,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqReq,
  output logic                 pushRet,
  output logic                 loadVector,
  output logic [PC_W-1:0]      pcVector
);
  ctrlStrobeT strb;
  logic globalEn, anyPend;
  logic [CORE_N-1:0] coreFlags;

  irqctl_ctrl u_ctrl (
    .cycleEnd(cycleEnd), .retIrq(retIrq), .regWrEn(regWrEn),
    .regAddr(regAddr), .wdGlobal(regWdata[GLB_BIT]),
    .anyPend(anyPend), .globalEn(globalEn), .strb(strb));

  irqctl_dp u_dp (
    .clk(clk), .rstN(rstN), .coreSrc(coreSrc), .periphASrc(periphASrc),
    .periphBSrc(periphBSrc), .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .regRdata(regRdata), .coreFlags(coreFlags),
    .globalEn(globalEn), .anyPend(anyPend));

  assign irqReq     = anyPend && globalEn;
  assign pushRet    = strb.take;
  assign loadVector = strb.take;
  assign pcVector   = VEC_ADDR;
endmodule

// File: rtl/irqctl_chk.sv
module irqctl_chk
  import irqctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cycleEnd,
  input logic              retIrq,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [CORE_N-1:0] coreSrc,
  input logic [CORE_N-1:0] coreFlags,
  input logic              irqReq,
  input logic              pushRet,
  input logic              loadVector,
  input logic              globalEn
);
  // R1
  a_r1_flag_latch: assert property (@(posedge clk) disable iff (!rstN)
    coreSrc[0] |=> coreFlags[0]);
  // R2
  a_r2_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> globalEn);
  // R4
  a_r4_entry_clears_global: assert property (@(posedge clk) disable iff (!rstN)
    pushRet |=> !globalEn);
  a_r4_strobes_paired: assert property (@(posedge clk) disable iff (!rstN)
    pushRet == loadVector);
  // R5
  a_r5_return_sets: assert property (@(posedge clk) disable iff (!rstN)
    (retIrq && !pushRet) |=> globalEn);
  // R7
  a_r7_drop_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_CORE && !regWdata[GLB_BIT]) |-> !pushRet);
  // R8
  a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    pushRet |-> (cycleEnd && irqReq));
endmodule

bind irqctl irqctl_chk u_chk (.*);

// File: tb/irqctl_test.sv
module irqctl_test;
  logic clk = 0, rstN = 0;
  logic [2:0] coreSrc = '0;
  logic [6:0] periphASrc = '0;
  logic [3:0] periphBSrc = '0;
  logic cycleEnd = 0, retIrq = 0, regWrEn = 0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irqReq, pushRet, loadVector;
  logic [12:0] pcVector;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqctl uut (.*);

  // register map vectors: {addr, write data, expected read}  (R10)
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'h38, 8'h38}, {3'd1, 8'hFF, 8'h7F}, {3'd2, 8'hAA, 8'h2A},
    {3'd3, 8'hFF, 8'h0F}, {3'd4, 8'h05, 8'h05}, {3'd5, 8'hFF, 8'h00},
    {3'd6, 8'h5A, 8'h00}, {3'd7, 8'h12, 8'h00}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a; #1 d = regRdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R3 reset state
    for (int i = 0; i < 5; i++) begin rd(3'(i), v); check("R3 reg", 16'(v), 0); end
    check("R3 irqReq", 16'(irqReq), 0);
    check("R3 pushRet", 16'(pushRet), 0);

    // R10 register map walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      check("R10 map", 16'(v), 16'(VEC[i][7:0]));
    end
    check("R10 no request with global off", 16'(irqReq), 0);
    for (int i = 0; i < 5; i++) wr(3'(i), 8'h00);

    // R1 flag latches while masked
    @(negedge clk); coreSrc = 3'b010;
    @(negedge clk); coreSrc = 0;
    rd(3'd0, v); check("R1 masked flag", 16'(v), 16'h02);
    check("R2 masked no req", 16'(irqReq), 0);

    // R2 enable without global, then global
    wr(3'd0, 8'h12);
    #1 check("R2 no global", 16'(irqReq), 0);
    wr(3'd0, 8'h92);
    #1 check("R2 req", 16'(irqReq), 1);

    // R8 no entry off boundary
    repeat (3) @(negedge clk);
    #1 check("R8 no entry", 16'(pushRet), 0);

    // R4 entry
    @(negedge clk); cycleEnd = 1;
    #1 check("R4 pushRet", 16'(pushRet), 1);
    check("R4 loadVector", 16'(loadVector), 1);
    check("R4 vector", 16'(pcVector), 16'h0004);
    @(negedge clk); cycleEnd = 0;
    rd(3'd0, v); check("R4 global cleared", 16'(v), 16'h12);
    check("R4 req dropped", 16'(irqReq), 0);

    // R6 / R5 re-trigger after return, then clear
    @(negedge clk); retIrq = 1;
    @(negedge clk); retIrq = 0;
    rd(3'd0, v); check("R5 global set", 16'(v), 16'h92);
    check("R6 re-request", 16'(irqReq), 1);
    wr(3'd0, 8'h90);
    #1 check("R6 cleared", 16'(irqReq), 0);

    // R7 drop on same-cycle global clear
    wr(3'd4, 8'h04);
    @(negedge clk); periphBSrc = 4'h4;
    @(negedge clk); periphBSrc = 0;
    #1 check("R7 req before", 16'(irqReq), 1);
    regAddr = 3'd0; regWdata = 8'h10; regWrEn = 1; cycleEnd = 1;
    #1 check("R7 dropped", 16'(pushRet), 0);
    @(negedge clk); regWrEn = 0; cycleEnd = 0;
    rd(3'd3, v); check("R7 flag pending", 16'(v), 16'h04);
    check("R7 no req", 16'(irqReq), 0);
    wr(3'd0, 8'h90);
    cycleEnd = 1;
    #1 check("R7 serviced later", 16'(pushRet), 1);
    @(negedge clk); cycleEnd = 0;

    // R9 hardware set beats software clear
    @(negedge clk); periphASrc = 7'h09;
    @(negedge clk); periphASrc = 7'h08; regAddr = 3'd1; regWdata = 8'h00; regWrEn = 1;
    @(negedge clk); periphASrc = 0; regWrEn = 0;
    rd(3'd1, v); check("R9 set wins", 16'(v), 16'h08);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule